// File: doc/BRIEF.md
# SPI Receive Deserializer

This block turns the serial data of an SPI frame into parallel words. It runs entirely on the sampling clock. That clock is produced outside the block: SCK is inverted when the clock-phase setting XOR the clock-polarity setting is 1, and passed straight through otherwise. On every rising edge of the sampling clock the block takes one chunk from a 4-lane serial input. A chunk is one, two or four bits, depending on the lane mode. When eight bits have arrived, the block presents the assembled word together with a strobe. A 12-bit count of every bit received in the current frame is also output.

Chip select gates the whole block. While chip select is high, or while the system reset is low, all state is held at zero. Any word that was only partly received at that moment is lost. The bit order can be set at run time: the first bits received become either the most significant end of the word or the least significant end.

The output stream has valid but no ready. The serial master cannot be stalled, so the block offers no back-pressure. A consumer must take the word during the strobe cycle or later, and before the next strobe. The word register holds its value until the next word completes or until the block is reset.

Top module: `spi_rx_deser`

## Requirements
- R1: While `sys_rst_ni` is low or `cs_ni` is high, `word_o` is 0, `word_vld_o` is 0 and `bit_cnt_o` is 0. Toggling the lanes in that state changes none of these outputs.
- R2: Lane mode code 2'b00 (single) takes one bit per edge from `lanes_i[0]`, and `lanes_i[3:1]` have no effect. The reserved code 2'b11 behaves exactly like 2'b00.
- R3: Lane mode code 2'b01 (dual) takes two bits per edge. The chunk is {`lanes_i[1]`, `lanes_i[0]`}, and `lanes_i[3:2]` have no effect.
- R4: Lane mode code 2'b10 (quad) takes four bits per edge. The chunk is `lanes_i[3:0]`, with lane k as chunk bit k.
- R5: With `lsb_first_i`=0 the first chunk of a word lands in the most significant bits and each later chunk lands just below the previous one. With `lsb_first_i`=1 the first chunk lands in bits [step-1:0] and each later chunk lands just above the previous one.
- R6: After the edge that completes the eighth bit of a word, `word_vld_o` is 1 for exactly one clock and `word_o` shows that word. `word_o` keeps that value until the next word completes.
- R7: `bit_cnt_o` rises by the number of bits taken on each edge and stays at 4095 rather than wrapping.
- R8: A partly received word is dropped without a strobe when chip select rises. The next frame starts assembling its first word from bit count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sample_clk_i | input | 1 | Sampling clock, already edge-selected outside the block |
| sys_rst_ni | input | 1 | System reset, active low, asynchronous |
| cs_ni | input | 1 | Chip select, active low; high holds the block in reset |
| lanes_i | input | 4 | Serial data lanes |
| lane_mode_i | input | 2 | 00 single, 01 dual, 10 quad, 11 treated as single |
| lsb_first_i | input | 1 | 0: the first chunk goes to the MSB end; 1: the first chunk goes to the LSB end |
| word_o | output | 8 | Last completed word |
| word_vld_o | output | 1 | One-cycle strobe for a completed word |
| bit_cnt_o | output | 12 | Saturating count of bits received in the frame |

## Verification
Two functions can act on the same edge: the completion of a word with its strobe, and the clamping of the bit counter at 4095. The bench provokes this with a long quad-mode frame. The counter reaches its limit while words are still arriving, so the strobe fires on the very edge where the counter clamps. On that edge the word and strobe must be correct while the count reads 4095. Later strobes must also be correct while the count stays at 4095.

// File: rtl/spi_rx_pkg.sv
`timescale 1ns/1ps
package spi_rx_pkg;
  typedef enum logic [1:0] {
    LANE_X1  = 2'b00,
    LANE_X2  = 2'b01,
    LANE_X4  = 2'b10,
    LANE_RSV = 2'b11
  } lane_mode_e;
endpackage

// File: rtl/spi_rx_lane_pick.sv
`timescale 1ns/1ps
module spi_rx_lane_pick #(
  parameter int LANES  = 4,
  parameter int STEP_W = $clog2(LANES) + 1
) (
  input  logic [LANES-1:0]  lanes_i,
  input  logic [1:0]        mode_i,
  output logic [LANES-1:0]  chunk_o,
  output logic [STEP_W-1:0] step_o
);
  import spi_rx_pkg::*;

  lane_mode_e mode;
  assign mode = lane_mode_e'(mode_i);

  always_comb begin
    chunk_o = '0;
    step_o  = STEP_W'(1);
    case (mode)
      LANE_X2: begin
        chunk_o[1:0] = lanes_i[1:0];
        step_o       = STEP_W'(2);
      end
      LANE_X4: begin
        chunk_o = lanes_i;
        step_o  = STEP_W'(LANES);
      end
      default: begin
        chunk_o[0] = lanes_i[0];
        step_o     = STEP_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/spi_rx_assembler.sv
`timescale 1ns/1ps
module spi_rx_assembler #(
  parameter int W      = 8,
  parameter int LANES  = 4,
  parameter int STEP_W = $clog2(LANES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  chunk_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              lsb_first_i,
  output logic [W-1:0]      word_o,
  output logic              word_vld_o
);
  localparam int FILL_W = $clog2(W) + 1;

  logic [W-1:0]      sh_q, asm_d, ext;
  logic [FILL_W-1:0] fill_q;
  logic [FILL_W:0]   fill_sum;
  logic              done;

  assign ext = W'(chunk_i);

  always_comb begin
    if (lsb_first_i) asm_d = (sh_q >> step_i) | (ext << (W - int'(step_i)));
    else             asm_d = (sh_q << step_i) | ext;
    fill_sum = (FILL_W+1)'(fill_q) + (FILL_W+1)'(step_i);
    done     = fill_sum >= (FILL_W+1)'(W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      fill_q     <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else if (done) begin
      sh_q       <= '0;
      fill_q     <= '0;
      word_o     <= asm_d;
      word_vld_o <= 1'b1;
    end else begin
      sh_q       <= asm_d;
      fill_q     <= fill_sum[FILL_W-1:0];
      word_vld_o <= 1'b0;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q < FILL_W'(W)); // R6
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o); // R6
  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_o |-> $stable(word_o)); // R6
endmodule

// File: rtl/spi_rx_bit_tally.sv
`timescale 1ns/1ps
module spi_rx_bit_tally #(
  parameter int CNT_W = 12,
  parameter int INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W:0] sum;
  assign sum = (CNT_W+1)'(cnt_o) + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (sum[CNT_W]) cnt_o <= CNT_MAX;
    else               cnt_o <= sum[CNT_W-1:0];
  end

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o == CNT_MAX |=> cnt_o == CNT_MAX); // R7
  AST_CNT_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o != CNT_MAX |=> cnt_o > $past(cnt_o)); // R7
endmodule

// File: rtl/spi_rx_deser.sv
`timescale 1ns/1ps
module spi_rx_deser #(
  parameter int W     = 8,
  parameter int LANES = 4,
  parameter int CNT_W = 12
) (
  input  logic             sample_clk_i,
  input  logic             sys_rst_ni,
  input  logic             cs_ni,
  input  logic [LANES-1:0] lanes_i,
  input  logic [1:0]       lane_mode_i,
  input  logic             lsb_first_i,
  output logic [W-1:0]     word_o,
  output logic             word_vld_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  localparam int STEP_W = $clog2(LANES) + 1;

  logic              rx_rst_n;
  logic [LANES-1:0]  chunk;
  logic [STEP_W-1:0] step;

  assign rx_rst_n = sys_rst_ni & ~cs_ni;

  spi_rx_lane_pick #(.LANES(LANES), .STEP_W(STEP_W)) u_pick (
    .lanes_i (lanes_i),
    .mode_i  (lane_mode_i),
    .chunk_o (chunk),
    .step_o  (step)
  );

  spi_rx_assembler #(.W(W), .LANES(LANES), .STEP_W(STEP_W)) u_asm (
    .clk_i       (sample_clk_i),
    .rst_ni      (rx_rst_n),
    .chunk_i     (chunk),
    .step_i      (step),
    .lsb_first_i (lsb_first_i),
    .word_o      (word_o),
    .word_vld_o  (word_vld_o)
  );

  spi_rx_bit_tally #(.CNT_W(CNT_W), .INC_W(STEP_W)) u_tally (
    .clk_i  (sample_clk_i),
    .rst_ni (rx_rst_n),
    .inc_i  (step),
    .cnt_o  (bit_cnt_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge sample_clk_i) disable iff (!sys_rst_ni)
    cs_ni |-> (!word_vld_o && bit_cnt_o == '0 && word_o == '0)); // R1
endmodule

// File: tb/sim_spi_rx_deser.sv
`timescale 1ns/1ps
module sim_spi_rx_deser;
  logic       clk = 1'b0;
  logic       sys_rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic [3:0] lanes = '0;
  logic [1:0] mode = 2'b00;
  logic       lsbf = 1'b0;
  logic [7:0] word;
  logic       vld;
  logic [11:0] cnt;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  int fill = 0;
  logic [7:0] exp_word = '0;

  always #2.5 clk = ~clk;

  spi_rx_deser u0 (
    .sample_clk_i(clk), .sys_rst_ni(sys_rst_n), .cs_ni(cs_n),
    .lanes_i(lanes), .lane_mode_i(mode), .lsb_first_i(lsbf),
    .word_o(word), .word_vld_o(vld), .bit_cnt_o(cnt));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int step_of(input logic [1:0] m);
    return (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
  endfunction

  function automatic int sat(input int v);
    return (v > 4095) ? 4095 : v;
  endfunction

  task automatic check_idle(input string req);
    chk(word == 8'h00, req, word, 0);
    chk(vld == 1'b0, req, vld, 0);
    chk(cnt == 12'd0, req, cnt, 0);
  endtask

  // Called at a negedge: drive one beat, then check at the next negedge.
  task automatic beat(input logic [3:0] v, input int s, input string req);
    lanes = v;
    @(negedge clk);
    exp_cnt = sat(exp_cnt + s);
    fill += s;
    if (fill >= 8) begin
      fill = 0;
      chk(vld == 1'b1, {req, " R6 strobe"}, vld, 1);
      chk(word == exp_word, {req, " R5 word"}, word, exp_word);
    end else begin
      chk(vld == 1'b0, "R6 no strobe mid-word", vld, 0);
    end
    chk(cnt == exp_cnt[11:0], "R7 count", cnt, exp_cnt);
  endtask

  task automatic send_word(input logic [7:0] d, input logic [1:0] m, input logic o,
                           input string req);
    int s;
    int mask;
    logic [3:0] v;
    s = step_of(m);
    mask = (1 << s) - 1;
    mode = m;
    lsbf = o;
    exp_word = d;
    for (int i = 0; i < 8 / s; i++) begin
      int c;
      if (o) c = (d >> (s * i)) & mask;
      else   c = (d >> (8 - s * (i + 1))) & mask;
      v = 4'(($urandom() & ~mask) | c);
      beat(v, s, req);
    end
  endtask

  task automatic start_frame();
    cs_n = 1'b0;
    exp_cnt = 0;
    fill = 0;
  endtask

  task automatic end_frame();
    cs_n = 1'b1;
    exp_cnt = 0;
    fill = 0;
    #1;
    check_idle("R1 idle after chip select rise");
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0107));
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    sys_rst_n = 1'b1;
    repeat (3) begin
      lanes = 4'($urandom());
      @(negedge clk);
      check_idle("R1 lanes ignored while chip select high");
    end

    // directed corners
    start_frame();
    send_word(8'hA5, 2'b00, 1'b0, "R2 single msb-first");
    send_word(8'h3C, 2'b00, 1'b1, "R2 R5 single lsb-first");
    send_word(8'h96, 2'b11, 1'b0, "R2 reserved code as single");
    send_word(8'hC6, 2'b01, 1'b0, "R3 dual msb-first");
    send_word(8'h1E, 2'b01, 1'b1, "R3 R5 dual lsb-first");
    send_word(8'h7B, 2'b10, 1'b0, "R4 quad msb-first");
    send_word(8'hE4, 2'b10, 1'b1, "R4 R5 quad lsb-first");
    // word stays after the strobe until the next completion
    lanes = 4'b0001;
    mode = 2'b00;
    @(negedge clk);
    exp_cnt = sat(exp_cnt + 1);
    fill = 1;
    chk(word == 8'hE4, "R6 word held after strobe", word, 8'hE4);
    // partial word dropped on chip select rise
    for (int i = 0; i < 4; i++) beat(4'($urandom()), 1, "R8 partial");
    chk(vld == 1'b0, "R8 no strobe for partial word", vld, 0);
    end_frame();
    start_frame();
    send_word(8'h5A, 2'b00, 1'b0, "R8 fresh word after abort");
    // system reset mid-word
    for (int i = 0; i < 3; i++) beat(4'($urandom()), 1, "R1 partial");
    sys_rst_n = 1'b0;
    #1;
    check_idle("R1 system reset mid-frame");
    @(negedge clk);
    sys_rst_n = 1'b1;
    exp_cnt = 0;
    fill = 0;
    send_word(8'h81, 2'b10, 1'b1, "R8 word after system reset");
    end_frame();

    // random frames
    for (int f = 0; f < 6; f++) begin
      start_frame();
      for (int k = 0; k < 12; k++)
        send_word(8'($urandom()), 2'($urandom()), 1'($urandom()), "R2 R3 R4 random");
      end_frame();
    end

    // long quad frame: counter clamps while words keep completing
    start_frame();
    for (int k = 0; k < 520; k++)
      send_word(8'($urandom()), 2'b10, 1'($urandom()), "R7 saturation");
    chk(cnt == 12'hFFF, "R7 saturated count", cnt, 12'hFFF);
    end_frame();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule